// File: doc/BRIEF.md
# Supply and Link Ready Monitor

This block decides whether a gate driver may pass switching commands through. It watches two digitized supply readings, one for the control side and one for the drive side, and a heartbeat pulse that arrives from the data link across the isolation barrier. Each supply runs through its own lockout comparator with separate engage and release thresholds. The heartbeat feeds a watchdog that counts down and is reloaded by every pulse.

Whenever any of the three conditions is bad, the block asserts a forced-off request. It also gates the incoming on command to zero, so commands given during a lockout are ignored. The active-high ready output combines the control-side supply status, which acts at once, with the drive-side supply status and the link status, which pass through a delay line of a set number of cycles. Ready has no latch: it follows the current conditions and recovers by itself once they are good again. The negative drive-side rail has no input and is not monitored.

Top module: `ready_lockout_monitor`

## Requirements
- R1: The control-side monitor, once healthy, locks out on the cycle after a reading strictly below IN_FALL_MV (default 3800 mV). At exactly 3800 it stays healthy. Once locked, it releases only on the cycle after a reading of at least IN_RISE_MV (default 4100 mV). A reading of 4099 keeps it locked.
- R2: The drive-side monitor works the same way with OUT_FALL_MV (default 11000 mV, locks strictly below) and OUT_RISE_MV (default 12000 mV, releases at or above). A reading of 11999 keeps it locked.
- R3: force_off is high whenever either supply is locked out or the link watchdog has expired. gate_cmd equals cmd_on when force_off is low and is 0 otherwise, so cmd_on has no effect during a lockout.
- R4: A control-side lockout drops ready, force_off and gate_cmd on the same cycle the lockout state takes effect, with no delay. A control-side release raises ready on that same cycle if the delayed status is already good.
- R5: Every link_beat pulse reloads the watchdog to WDOG_CYCLES (default 20). The link counts as failed once WDOG_CYCLES consecutive clock edges have passed with no pulse. Pulses spaced exactly WDOG_CYCLES apart keep the link healthy without a gap.
- R6: The combined drive-side and link status reaches ready STATUS_DELAY cycles (default 4) after it changes, on both falling and rising changes, while force_off reacts at once.
- R7: ready has no latch. After every condition becomes good again, it returns high by itself with no reset.
- R8: During and right after a synchronous reset, ready is 0, force_off is 1 and gate_cmd is 0. Both supplies start locked out, the watchdog starts expired, and the delay line starts filled with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vin_mv | input | 16 | Control-side supply reading, unsigned millivolts |
| vout_mv | input | 16 | Drive-side supply reading, unsigned millivolts |
| link_beat | input | 1 | Heartbeat pulse from the isolation data link |
| cmd_on | input | 1 | Gate on command from the control logic |
| ready | output | 1 | Active-high ready status |
| force_off | output | 1 | Request to force the gate off |
| gate_cmd | output | 1 | Qualified gate command toward the drive side |

## Verification
The assertions assume the supply readings are already synchronous and settled within each cycle. They also assume link_beat is a clean level sampled on the clock edge, so a heartbeat held high for several cycles counts as several reloads. The stimulus changes every input only at the falling clock edge. It steps the readings exactly onto and one code away from each threshold, and it runs the heartbeat regularly, in bursts, spaced exactly at the timeout, and not at all. The bench model keeps its own countdown and delay queue, so every output is compared on every clock against independent expectations.

// File: rtl/rdy_mon_pkg.sv
package rdy_mon_pkg;

   typedef struct packed {
      logic in_ok;
      logic out_ok;
      logic link_ok;
   } health_t;

   function automatic logic all_good(health_t h);
      return h.in_ok & h.out_ok & h.link_ok;
   endfunction

   function automatic logic delayed_part(health_t h);
      return h.out_ok & h.link_ok;
   endfunction

endpackage

// File: rtl/uvlo_hysteresis.sv
module uvlo_hysteresis #(
   parameter int W       = 16,
   parameter int RISE_MV = 4100,
   parameter int FALL_MV = 3800
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] level,
   output logic         ok
);
   localparam logic [W-1:0] RISE_C = W'(RISE_MV);
   localparam logic [W-1:0] FALL_C = W'(FALL_MV);

   initial begin
      assert (RISE_MV > FALL_MV) else $error("release threshold must exceed engage threshold");
      assert (RISE_MV < (1 << W)) else $error("release threshold does not fit the reading width");
   end

   always_ff @(posedge clk) begin
      if (rst)                        ok <= 1'b0;
      else if (ok  && level < FALL_C) ok <= 1'b0;
      else if (!ok && level >= RISE_C) ok <= 1'b1;
   end

   AST_LOCK_BELOW_FALL: assert property (@(posedge clk) disable iff (rst)
      (ok && level < FALL_C) |=> !ok); // R1
   AST_HOLD_ABOVE_FALL: assert property (@(posedge clk) disable iff (rst)
      (ok && level >= FALL_C) |=> ok); // R2
   AST_RELEASE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
      (!ok && level >= RISE_C) |=> ok); // R1
   AST_STAY_LOCKED: assert property (@(posedge clk) disable iff (rst)
      (!ok && level < RISE_C) |=> !ok); // R2
endmodule

// File: rtl/link_watchdog.sv
module link_watchdog #(
   parameter int WDOG_CYCLES = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic beat,
   output logic link_ok
);
   localparam int CW = $clog2(WDOG_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(WDOG_CYCLES);

   logic [CW-1:0] remain;

   initial begin
      assert (WDOG_CYCLES >= 1) else $error("watchdog needs at least one cycle");
   end

   always_ff @(posedge clk) begin
      if (rst)                remain <= '0;
      else if (beat)          remain <= LOAD;
      else if (remain != '0)  remain <= remain - 1'b1;
   end

   assign link_ok = (remain != '0);

   AST_BEAT_RELOADS: assert property (@(posedge clk) disable iff (rst)
      beat |=> link_ok); // R5
   AST_NO_SELF_REVIVE: assert property (@(posedge clk) disable iff (rst)
      (!link_ok && !beat) |=> !link_ok); // R5
endmodule

// File: rtl/status_delay_line.sv
module status_delay_line #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   initial begin
      assert (DEPTH >= 0 && DEPTH <= 256) else $error("delay depth out of range");
   end

   generate
      if (DEPTH == 0) begin : g_pass
         assign dout = din;
      end else if (DEPTH == 1) begin : g_one
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
         assign dout = q;
      end else begin : g_shift
         logic [DEPTH-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= {q[DEPTH-2:0], din};
         end
         assign dout = q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/ready_lockout_monitor.sv
module ready_lockout_monitor #(
   parameter int W            = 16,
   parameter int IN_RISE_MV   = 4100,
   parameter int IN_FALL_MV   = 3800,
   parameter int OUT_RISE_MV  = 12000,
   parameter int OUT_FALL_MV  = 11000,
   parameter int WDOG_CYCLES  = 20,
   parameter int STATUS_DELAY = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] vin_mv,
   input  logic [W-1:0] vout_mv,
   input  logic         link_beat,
   input  logic         cmd_on,
   output logic         ready,
   output logic         force_off,
   output logic         gate_cmd
);
   import rdy_mon_pkg::*;

   localparam int NSUP = 2;

   logic [NSUP-1:0] sup_ok;
   logic            link_ok;
   logic            late_ok;
   health_t         h;

   generate
      for (genvar s = 0; s < NSUP; s++) begin : g_supply
         localparam int RISE = (s == 0) ? IN_RISE_MV : OUT_RISE_MV;
         localparam int FALL = (s == 0) ? IN_FALL_MV : OUT_FALL_MV;
         uvlo_hysteresis #(.W(W), .RISE_MV(RISE), .FALL_MV(FALL)) i_uvlo (
            .clk   (clk),
            .rst   (rst),
            .level ((s == 0) ? vin_mv : vout_mv),
            .ok    (sup_ok[s])
         );
      end
   endgenerate

   link_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) i_wdog (
      .clk     (clk),
      .rst     (rst),
      .beat    (link_beat),
      .link_ok (link_ok)
   );

   assign h.in_ok   = sup_ok[0];
   assign h.out_ok  = sup_ok[1];
   assign h.link_ok = link_ok;

   status_delay_line #(.DEPTH(STATUS_DELAY)) i_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (delayed_part(h)),
      .dout (late_ok)
   );

   assign force_off = ~all_good(h);
   assign gate_cmd  = cmd_on & all_good(h);
   assign ready     = h.in_ok & late_ok;

   AST_CTRL_LOCK_KILLS_ALL: assert property (@(posedge clk) disable iff (rst)
      !sup_ok[0] |-> (!ready && !gate_cmd && force_off)); // R4
   AST_DRIVE_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (!sup_ok[1] || !link_ok) |-> (!gate_cmd && force_off)); // R3
   AST_READY_NEEDS_CTRL: assert property (@(posedge clk) disable iff (rst)
      $fell(sup_ok[0]) |-> !ready); // R4
   AST_RESET_STATE: assert property (@(posedge clk)
      $past(rst) |-> (!ready && force_off && !gate_cmd)); // R8
endmodule

// File: tb/test_ready_lockout_monitor.sv
module test_ready_lockout_monitor;
   localparam int WD = 20;
   localparam int DL = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] vin_mv = '0;
   logic [15:0] vout_mv = '0;
   logic        link_beat = 1'b0;
   logic        cmd_on = 1'b0;
   logic        ready, force_off, gate_cmd;

   always #4 clk = ~clk;

   ready_lockout_monitor #(.WDOG_CYCLES(WD), .STATUS_DELAY(DL)) i_ready_lockout_monitor (
      .clk(clk), .rst(rst), .vin_mv(vin_mv), .vout_mv(vout_mv),
      .link_beat(link_beat), .cmd_on(cmd_on),
      .ready(ready), .force_off(force_off), .gate_cmd(gate_cmd)
   );

   int    n_tests = 0;
   int    n_fail = 0;
   int    cyc = 0;
   int    beat_period = 0;
   string cur_req = "R8";

   // behavioural reference
   bit m_in, m_out;
   int m_cnt;
   bit mq[$];

   always @(posedge clk) begin
      if (rst) begin
         m_in = 0; m_out = 0; m_cnt = 0;
         mq = {};
         for (int i = 0; i < DL; i++) mq.push_back(1'b0);
      end else begin
         mq.push_back(m_out && (m_cnt != 0));
         void'(mq.pop_front());
         if (m_in) m_in = !(vin_mv < 16'd3800); else m_in = (vin_mv >= 16'd4100);
         if (m_out) m_out = !(vout_mv < 16'd11000); else m_out = (vout_mv >= 16'd12000);
         if (link_beat) m_cnt = WD;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         begin
            bit ef;
            ef = !(m_in && m_out && (m_cnt != 0));
            chk(cur_req, "model ready", ready, m_in && mq[0]);
            chk(cur_req, "model force_off", force_off, ef);
            chk(cur_req, "model gate_cmd", gate_cmd, cmd_on && !ef);
         end
         cyc++;
         link_beat = (beat_period != 0) && (cyc % beat_period == 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      cur_req = "R8";
      tick(3);
      chk("R8", "reset ready", ready, 1'b0);
      chk("R8", "reset force_off", force_off, 1'b1);
      chk("R8", "reset gate_cmd", gate_cmd, 1'b0);
      rst = 1'b0;
      vin_mv = 16'd4100; vout_mv = 16'd12000; cmd_on = 1'b1; beat_period = 5;
      tick(1);
      chk("R8", "no ready straight after reset", ready, 1'b0);
      cur_req = "R6";
      tick(14);
      chk("R6", "ready after bring-up", ready, 1'b1);
      chk("R3", "gate follows cmd", gate_cmd, 1'b1);
      cmd_on = 1'b0; tick(1);
      chk("R3", "gate follows cmd low", gate_cmd, 1'b0);
      cmd_on = 1'b1;

      cur_req = "R1";
      vin_mv = 16'd3800; tick(3);
      chk("R1", "3800 keeps supply healthy", force_off, 1'b0);
      vin_mv = 16'd3799; tick(1);
      chk("R4", "ctrl lockout force_off", force_off, 1'b1);
      chk("R4", "ctrl lockout ready immediate", ready, 1'b0);
      chk("R4", "ctrl lockout gate", gate_cmd, 1'b0);
      vin_mv = 16'd4099; cur_req = "R3";
      for (int i = 0; i < 6; i++) begin
         cmd_on = i[0];
         tick(1);
         chk("R3", "cmd ignored in lockout", gate_cmd, 1'b0);
      end
      chk("R1", "4099 stays locked", force_off, 1'b1);
      cmd_on = 1'b1; vin_mv = 16'd4100; cur_req = "R4";
      tick(1);
      chk("R4", "ctrl release ready immediate", ready, 1'b1);
      chk("R1", "release at 4100", gate_cmd, 1'b1);

      cur_req = "R2";
      vout_mv = 16'd11000; tick(3);
      chk("R2", "11000 keeps drive healthy", force_off, 1'b0);
      vout_mv = 16'd10999; tick(1);
      chk("R3", "drive lockout force_off", force_off, 1'b1);
      chk("R6", "ready held by delay", ready, 1'b1);
      cur_req = "R6";
      tick(DL - 1);
      chk("R6", "ready still high at delay-1", ready, 1'b1);
      tick(1);
      chk("R6", "ready low after delay", ready, 1'b0);
      vout_mv = 16'd11999; cur_req = "R2"; tick(3);
      chk("R2", "11999 stays locked", force_off, 1'b1);
      vout_mv = 16'd12000; tick(1);
      chk("R2", "release at 12000", force_off, 1'b0);
      chk("R6", "ready waits for delay on rise", ready, 1'b0);
      cur_req = "R7"; tick(DL);
      chk("R7", "ready recovers without reset", ready, 1'b1);

      cur_req = "R5";
      beat_period = 0; tick(WD + 2);
      chk("R5", "link timeout forces off", force_off, 1'b1);
      chk("R5", "link timeout blocks gate", gate_cmd, 1'b0);
      tick(DL + 1);
      chk("R5", "link timeout drops ready", ready, 1'b0);
      beat_period = 1; tick(DL + 3);
      chk("R7", "ready back after beats resume", ready, 1'b1);
      beat_period = WD; tick(WD);
      begin
         int drops = 0;
         for (int i = 0; i < 3 * WD; i++) begin
            tick(1);
            if (force_off) drops++;
         end
         chk("R5", "beats at timeout spacing keep link", drops != 0, 1'b0);
      end

      cur_req = "R8";
      rst = 1'b1; tick(2);
      chk("R8", "mid-run reset ready", ready, 1'b0);
      chk("R8", "mid-run reset force_off", force_off, 1'b1);
      rst = 1'b0; beat_period = 5; tick(DL + 8);
      chk("R7", "ready after second reset", ready, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule